// File: doc/BRIEF.md
# Masked Priority Interrupt Vector Encoder

This block gathers sixteen interrupt requests into a pending register, gates them with a software-written mask, and raises a single request line toward the processor whenever an enabled source is waiting. The sources form one fixed priority chain. Even-numbered indices are external pins and odd-numbered indices are internal levels, so the order is pin 0, level 0, pin 1, level 1, and so on up to level 7. Index 0 is the most urgent source.

Software reads a vector register to learn which source to service. The vector is the winning index multiplied by four, which lets a handler add it directly to the base of a table of word-sized handler addresses. When nothing enabled is pending, the vector holds an idle code of 0x40, one step past the last real entry. Requests are level-sensitive. A source stays pending for as long as its device holds the request, and it drops out when the device releases it.

Access goes through a small register bus. It offers a two-bit address, a write strobe, write data and combinational read data.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the pending register reads 0x0000, the mask reads 0x0000, the vector reads the idle code and irq_o is low.
- R2: Bit n of the pending register (address 0) equals src_req[n] as sampled on the previous clock edge, independent of the mask.
- R3: A pending bit returns to 0 one clock after its request input is released; no write is needed to clear it.
- R4: Writes to the pending register, to the vector register (address 2) and to address 3 change no register state.
- R5: The mask register (address 1) is read/write and its bit 15−n enables source n (level 4 = 0x0040, level 5 = 0x0010, level 3 = 0x0100).
- R6: irq_o is high exactly when some source is both pending and enabled by its mask bit.
- R7: Reading address 2 returns the winning index times four in bits 15:8 (0x00 for pin 0 up to 0x3C for level 7, level 4 = 0x24) and zero in bits 7:0; the winner is the lowest-index source that is pending and enabled.
- R8: A pending source that is masked never hides a lower-priority source that is pending and enabled.
- R9: When no enabled source is pending, the vector field reads 0x40.
- R10: Address 3 reads as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 16 | Level-sensitive requests; bit n is source index n |
| bus_addr | input | 2 | Register select: 0 pending, 1 mask, 2 vector, 3 unused |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| irq_o | output | 1 | Request to the processor |

## Verification
The bench holds three neighbouring levels pending at once and rotates the mask through their enable bits. An encoder that ignored the mask would always report the topmost level, and one that let a masked source win would report an idle or wrong vector. It also lays out the whole request word against one low-priority enable bit and against the full mask. These runs catch a mask mapped without the bit reversal and a search that runs in the wrong direction. Writes aimed at the read-only and unused addresses, and requests released after service, show whether the pending register wrongly takes software writes or behaves as a sticky latch.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_PEND = 2'd0,
      SEL_MASK = 2'd1,
      SEL_VEC  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // scaling of the winning index into a table offset (word entries)
   localparam int unsigned SCALE_SH = 2;
endpackage

// File: rtl/intc_src_capture.sv
module intc_src_capture #(
   parameter int unsigned N_SRC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req_i,
   output logic [N_SRC-1:0] pend_o
);
   // level-sensitive: the register mirrors the request lines
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= req_i;
   end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
   parameter int unsigned N_SRC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [N_SRC-1:0] wdata_i,
   output logic [N_SRC-1:0] mask_o,
   output logic [N_SRC-1:0] en_by_idx_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_o <= '0;
      else if (wr_en_i) mask_o <= wdata_i;
   end

   // source n is enabled by mask bit N_SRC-1-n
   for (genvar g = 0; g < N_SRC; g++) begin : g_rev
      assign en_by_idx_o[g] = mask_o[N_SRC-1-g];
   end
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
   parameter int unsigned N_SRC = 16,
   localparam int unsigned IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] active_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);
   // lowest index wins: scan from the bottom of the priority chain upward
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (active_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
   parameter int unsigned N_SRC   = 16,
   parameter int unsigned VEC_W   = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_req,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [N_SRC-1:0] bus_wdata,
   output logic [N_SRC-1:0] bus_rdata,
   output logic             irq_o
);
   import intc_pkg::*;

   localparam int unsigned IDX_W    = $clog2(N_SRC);
   localparam int unsigned DATA_W   = N_SRC;
   localparam int unsigned PAD_W    = VEC_W - IDX_W - SCALE_SH;
   localparam logic [VEC_W-1:0] IDLE_VEC = VEC_W'(N_SRC << SCALE_SH);

   if ((N_SRC << SCALE_SH) >= (1 << VEC_W)) begin : g_chk_vec
      $error("vector field too narrow for idle code");
   end
   if (VEC_W > DATA_W) begin : g_chk_bus
      $error("vector field wider than data bus");
   end
   if (N_SRC < 2) begin : g_chk_src
      $error("at least two sources required");
   end

   reg_sel_e         sel;
   logic [N_SRC-1:0] pend_q;
   logic [N_SRC-1:0] mask_q;
   logic [N_SRC-1:0] en_by_idx;
   logic [N_SRC-1:0] active;
   logic             found;
   logic [IDX_W-1:0] win_idx;
   logic [VEC_W-1:0] vec_comb;
   logic [VEC_W-1:0] vec_out;

   assign sel = reg_sel_e'(bus_addr);

   intc_src_capture #(.N_SRC(N_SRC)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (src_req),
      .pend_o (pend_q)
   );

   intc_mask_reg #(.N_SRC(N_SRC)) u_mask (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (bus_wr && (sel == SEL_MASK)),
      .wdata_i     (bus_wdata),
      .mask_o      (mask_q),
      .en_by_idx_o (en_by_idx)
   );

   assign active = pend_q & en_by_idx;

   intc_prio_enc #(.N_SRC(N_SRC)) u_enc (
      .active_i (active),
      .found_o  (found),
      .idx_o    (win_idx)
   );

   assign vec_comb = found ? {{PAD_W{1'b0}}, win_idx, {SCALE_SH{1'b0}}} : IDLE_VEC;

   if (REG_OUT) begin : g_reg_out
      logic [VEC_W-1:0] vec_q;
      logic             irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vec_q <= IDLE_VEC;
            irq_q <= 1'b0;
         end else begin
            vec_q <= vec_comb;
            irq_q <= found;
         end
      end
      assign vec_out = vec_q;
      assign irq_o   = irq_q;
   end else begin : g_comb_out
      assign vec_out = vec_comb;
      assign irq_o   = found;
   end

   always_comb begin
      unique case (sel)
         SEL_PEND: bus_rdata = pend_q;
         SEL_MASK: bus_rdata = mask_q;
         SEL_VEC:  bus_rdata = {vec_out, {(DATA_W-VEC_W){1'b0}}};
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk #(
   parameter int unsigned N_SRC   = 16,
   parameter int unsigned VEC_W   = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] src_req,
   input logic [1:0]       bus_addr,
   input logic             bus_wr,
   input logic [N_SRC-1:0] bus_rdata,
   input logic             irq_o,
   input logic [N_SRC-1:0] pend_q,
   input logic [N_SRC-1:0] mask_q
);
   localparam logic [VEC_W-1:0] IDLE = VEC_W'(N_SRC << 2);

   logic [N_SRC-1:0] en_rev;
   always_comb begin
      for (int i = 0; i < N_SRC; i++) en_rev[i] = mask_q[N_SRC-1-i];
   end
   logic any_live;
   assign any_live = |(pend_q & en_rev);

   AST_PEND_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (pend_q == $past(src_req))); // R2

   AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == 2'd1) |=> $stable(mask_q)); // R5

   AST_VEC_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd2) |-> (bus_rdata[N_SRC-VEC_W-1:0] == '0 && bus_rdata[N_SRC-VEC_W+1 -: 2] == 2'b00)); // R7

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd3) |-> (bus_rdata == '0)); // R10

   if (REG_OUT) begin : g_reg
      AST_IRQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (irq_o == $past(any_live))); // R6
   end else begin : g_comb
      AST_IRQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o == any_live); // R6
      AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr == 2'd2 && !any_live) |-> (bus_rdata[N_SRC-1 -: VEC_W] == IDLE)); // R9
   end
endmodule

bind prio_vec_intc prio_vec_intc_chk #(
   .N_SRC(N_SRC), .VEC_W(VEC_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_req   (src_req),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .irq_o     (irq_o),
   .pend_q    (pend_q),
   .mask_q    (mask_q)
);

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] src_req = '0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   prio_vec_intc u_dut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   // {req, mask, expected vector byte, expected irq}
   localparam int NV = 10;
   localparam logic [40:0] VEC_TAB [NV] = '{
      {16'h0010, 16'h0800, 8'h10, 1'b1},  // pin 2 alone
      {16'h0200, 16'h0040, 8'h24, 1'b1},  // level 4
      {16'h0A80, 16'h0040, 8'h24, 1'b1},  // levels 3,4,5; only 4 enabled
      {16'h0A80, 16'h0050, 8'h24, 1'b1},  // 4 and 5 enabled
      {16'h0A80, 16'h0140, 8'h1C, 1'b1},  // 3 and 4 enabled
      {16'h0A80, 16'h0010, 8'h2C, 1'b1},  // only 5 enabled
      {16'hFFFF, 16'h0001, 8'h3C, 1'b1},  // everything, level 7 enabled
      {16'hFFFF, 16'hFFFF, 8'h00, 1'b1},  // everything enabled
      {16'h0200, 16'hFFBF, 8'h40, 1'b0},  // level 4 masked
      {16'h0000, 16'hFFFF, 8'h40, 1'b0}   // nothing pending
   };

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      repeat (3) @(negedge clk);
      // R1 reset state
      bus_read(2'd0, rd); check("R1 pending", rd, 16'h0000);
      bus_read(2'd1, rd); check("R1 mask", rd, 16'h0000);
      bus_read(2'd2, rd); check("R1 vector", rd, 16'h4000);
      check("R1 irq", {15'b0, irq_o}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         src_req = VEC_TAB[k][40:25];
         bus_write(2'd1, VEC_TAB[k][24:9]);   // mask and pending both settle here
         bus_read(2'd1, rd); check("R5 mask readback", rd, VEC_TAB[k][24:9]);
         bus_read(2'd0, rd); check("R2 pending mirrors req", rd, VEC_TAB[k][40:25]);
         bus_read(2'd2, rd); check("R7 R8 R9 vector", rd, {VEC_TAB[k][8:1], 8'h00});
         check("R6 irq", {15'b0, irq_o}, {15'b0, VEC_TAB[k][0]});
      end

      // R3: release after service
      src_req = 16'h0200;
      bus_write(2'd1, 16'h0040);
      check("R3 irq while held", {15'b0, irq_o}, 16'h0001);
      src_req = 16'h0000;
      @(negedge clk);
      bus_read(2'd0, rd); check("R3 pending cleared", rd, 16'h0000);
      check("R3 irq dropped", {15'b0, irq_o}, 16'h0000);

      // R4: writes to read-only and unused addresses
      bus_write(2'd0, 16'hFFFF);
      bus_read(2'd0, rd); check("R4 pending ignores write", rd, 16'h0000);
      bus_write(2'd2, 16'h1234);
      bus_read(2'd2, rd); check("R4 vector ignores write", rd, 16'h4000);
      bus_read(2'd1, rd); check("R4 mask unchanged", rd, 16'h0040);
      bus_write(2'd3, 16'hFFFF);
      bus_read(2'd1, rd); check("R4 mask unchanged by addr3", rd, 16'h0040);
      check("R4 irq stays low", {15'b0, irq_o}, 16'h0000);
      // R10
      bus_read(2'd3, rd); check("R10 unused reads zero", rd, 16'h0000);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule